// File: doc/BRIEF.md
# Machine-Cycle Timebase and Reset Sequencer

This block sits next to a small processor core and turns the raw input clock into the enables the rest of the core runs on. While the clock is running it gives a strobe once per four-clock machine cycle and one tick strobe per timer. Each timer has its own rate bit. With the bit set, the timer ticks on every machine cycle. With the bit clear, it ticks on every third machine cycle, which is every twelve clocks.

It also sequences reset and the clock-stop low-power state. When the power-up indication is released, the core is kept in reset for a fixed number of clocks, and a sticky power-on flag is raised. Only an explicit clear strobe lowers that flag. A stop request halts the gated clock enable and every strobe. Any of the wake-up edge events, or an external reset, starts the same settling count that power-up uses. The clock enable returns only when that count is complete, and both prescalers start again from phase zero.

Top module: `ctb_timebase`

## Requirements
- R1: After `por_n` rises, `core_rst` stays 1 and `clk_en` stays 0 for exactly SETTLE_CLKS rising clock edges. From the SETTLE_CLKS-th edge on, `core_rst` is 0 and `clk_en` is 1.
- R2: Driving `por_n` low sets `por_flag` to 1 at once. The flag goes to 0 only on the edge after a cycle with `flag_clr` high. Nothing else changes it.
- R3: While `ext_rst` is 1, `core_rst` is 1 in the same cycle and every strobe is 0. `por_flag` is left unchanged. If the clock is running, the prescalers are cleared, so the first machine-cycle strobe comes in the 4th cycle after `ext_rst` falls.
- R4: `mc_stb` is 1 in every 4th cycle while running, independent of `rate_sel`. The first strobe is in the 4th running cycle.
- R5: Bit i of `rate_sel` controls timer i (bit 2 is timer 2, bit 1 is timer 1, bit 0 is timer 0). When the bit is 1, `tmr_tick[i]` pulses with every `mc_stb`. When the bit is 0, it pulses with every third `mc_stb`, starting with the third after a restart.
- R6: A cycle with `stop_wr` high while running, without `ext_rst`, makes `clk_en` 0 from the next cycle on. `mc_stb` and `tmr_tick` stay 0 for the whole stop state.
- R7: In the stop state, an edge event on any bit of `wake_evt` starts a settling count. `clk_en` returns SETTLE_CLKS edges after the edge that sampled the event, and the prescalers restart from phase zero.
- R8: `wake_evt` pulses have no effect while the clock is running. `clk_en` stays 1 and the strobe pattern continues.
- R9: An `ext_rst` pulse in the stop state also leaves stop, through the same settling count as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| por_n | input | 1 | Power-up indication, low while power is not yet good (asynchronous) |
| ext_rst | input | 1 | External reset request, active high, sampled on the clock |
| stop_wr | input | 1 | One-cycle write strobe of the stop-request bit |
| wake_evt | input | N_WAKE | Detected wake-up edge events, one per external edge interrupt |
| rate_sel | input | N_TMR | Per-timer rate bits: 1 gives a 4-clock tick, 0 gives a 12-clock tick |
| flag_clr | input | 1 | Software write of 0 to the power-on flag |
| core_rst | output | 1 | Reset to the core |
| clk_en | output | 1 | Gated-clock enable |
| mc_stb | output | 1 | Machine-cycle strobe |
| tmr_tick | output | N_TMR | Per-timer tick strobes |
| por_flag | output | 1 | Sticky power-on flag |

## Verification
Two overlaps get the closest scrutiny. The first is an external reset arriving while the block sits in stop, so that reset and stop exit meet. The second is a batch of wake events, together with a rate-bit change, landing in the middle of a running strobe pattern. The bench raises `ext_rst` four cycles into a stop period. It expects `core_rst` in that very cycle and then a full settling count before `clk_en` returns. For the second overlap it pulses all wake bits plus new rate bits while running. It expects `clk_en` to stay high and the next strobes to follow the new rates on the unbroken four-clock grid.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

   typedef enum logic [1:0] {
      ST_HOLD   = 2'd0,
      ST_RUN    = 2'd1,
      ST_STOP   = 2'd2,
      ST_SETTLE = 2'd3
   } ctb_state_e;

endpackage

// File: rtl/ctb_sequencer.sv
module ctb_sequencer
   import ctb_pkg::*;
#(
   parameter int SETTLE_CLKS = 65536,
   parameter int N_WAKE      = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst,
   input  logic              stop_wr,
   input  logic [N_WAKE-1:0] wake_evt,
   output ctb_state_e        state_o
);

   localparam int CNT_W = $clog2(SETTLE_CLKS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CLKS - 1);

   ctb_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   // one counter shared by power-up hold and stop settling
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= ST_HOLD;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_HOLD, ST_SETTLE: begin
               if (cnt_q == CNT_LAST) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RUN: begin
               if (stop_wr && !ext_rst) state_q <= ST_STOP;
            end
            ST_STOP: begin
               if ((|wake_evt) || ext_rst) begin
                  state_q <= ST_SETTLE;
                  cnt_q   <= '0;
               end
            end
            default: state_q <= ST_HOLD;
         endcase
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/ctb_prescaler.sv
module ctb_prescaler #(
   parameter int MC_CLKS   = 4,
   parameter int SLOW_MULT = 3
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   output logic fast_stb,
   output logic slow_stb
);

   localparam int PH_W = $clog2(MC_CLKS);
   localparam int DV_W = $clog2(SLOW_MULT);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);
   localparam logic [DV_W-1:0] DV_LAST = DV_W'(SLOW_MULT - 1);

   logic [PH_W-1:0] ph_q;
   logic [DV_W-1:0] dv_q;
   logic            ph_wrap;

   assign ph_wrap = (ph_q == PH_LAST);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ph_q <= '0;
         dv_q <= '0;
      end else if (clr) begin
         ph_q <= '0;
         dv_q <= '0;
      end else begin
         ph_q <= ph_wrap ? '0 : ph_q + 1'b1;
         if (ph_wrap) dv_q <= (dv_q == DV_LAST) ? '0 : dv_q + 1'b1;
      end
   end

   assign fast_stb = !clr && ph_wrap;
   assign slow_stb = fast_stb && (dv_q == DV_LAST);

endmodule

// File: rtl/ctb_tick_mux.sv
module ctb_tick_mux #(
   parameter int N_TMR = 3
) (
   input  logic [N_TMR-1:0] rate_sel,
   input  logic             fast_stb,
   input  logic             slow_stb,
   output logic [N_TMR-1:0] tick
);

   for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      assign tick[i] = rate_sel[i] ? fast_stb : slow_stb;
   end

endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase
   import ctb_pkg::*;
#(
   parameter int SETTLE_CLKS = 65536,
   parameter int MC_CLKS     = 4,
   parameter int SLOW_MULT   = 3,
   parameter int N_TMR       = 3,
   parameter int N_WAKE      = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst,
   input  logic              stop_wr,
   input  logic [N_WAKE-1:0] wake_evt,
   input  logic [N_TMR-1:0]  rate_sel,
   input  logic              flag_clr,
   output logic              core_rst,
   output logic              clk_en,
   output logic              mc_stb,
   output logic [N_TMR-1:0]  tmr_tick,
   output logic              por_flag
);

   if (SETTLE_CLKS < 2) begin : g_bad_settle
      $error("SETTLE_CLKS must be at least 2");
   end
   if (MC_CLKS < 2) begin : g_bad_mc
      $error("MC_CLKS must be at least 2");
   end
   if (SLOW_MULT < 2) begin : g_bad_mult
      $error("SLOW_MULT must be at least 2");
   end
   if (N_TMR < 1 || N_WAKE < 1) begin : g_bad_cnt
      $error("N_TMR and N_WAKE must be at least 1");
   end

   ctb_state_e state;
   logic       running;
   logic       fast_stb;
   logic       slow_stb;
   logic       flag_q;

   ctb_sequencer #(
      .SETTLE_CLKS(SETTLE_CLKS),
      .N_WAKE     (N_WAKE)
   ) u_seq (
      .clk     (clk),
      .por_n   (por_n),
      .ext_rst (ext_rst),
      .stop_wr (stop_wr),
      .wake_evt(wake_evt),
      .state_o (state)
   );

   assign running = (state == ST_RUN);

   ctb_prescaler #(
      .MC_CLKS  (MC_CLKS),
      .SLOW_MULT(SLOW_MULT)
   ) u_presc (
      .clk     (clk),
      .por_n   (por_n),
      .clr     (!running || ext_rst),
      .fast_stb(fast_stb),
      .slow_stb(slow_stb)
   );

   ctb_tick_mux #(
      .N_TMR(N_TMR)
   ) u_mux (
      .rate_sel(rate_sel),
      .fast_stb(fast_stb),
      .slow_stb(slow_stb),
      .tick    (tmr_tick)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign core_rst = (state == ST_HOLD) || ext_rst;
   assign clk_en   = running;
   assign mc_stb   = fast_stb;
   assign por_flag = flag_q;

endmodule

// File: rtl/ctb_timebase_chk.sv
module ctb_timebase_chk #(
   parameter int N_TMR = 3
) (
   input logic             clk,
   input logic             por_n,
   input logic             ext_rst,
   input logic             stop_wr,
   input logic             flag_clr,
   input logic             core_rst,
   input logic             clk_en,
   input logic             mc_stb,
   input logic [N_TMR-1:0] tmr_tick,
   input logic             por_flag
);

   // R1
   hold_no_clk_chk: assert property (@(posedge clk) disable iff (!por_n)
      (core_rst && !ext_rst) |-> !clk_en);

   // R2
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (por_flag && !flag_clr) |=> por_flag);

   // R3
   ext_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
      ext_rst |-> (core_rst && !mc_stb));

   // R4
   mc_spacing_chk: assert property (@(posedge clk) disable iff (!por_n)
      mc_stb |=> !mc_stb);

   // R6
   mc_gated_chk: assert property (@(posedge clk) disable iff (!por_n)
      mc_stb |-> clk_en);

   // R5
   tick_on_mc_chk: assert property (@(posedge clk) disable iff (!por_n)
      (|tmr_tick) |-> mc_stb);

   // R6
   stop_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
      (clk_en && stop_wr && !ext_rst) |=> !clk_en);

   // R8
   run_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
      (clk_en && !stop_wr) |=> clk_en);

endmodule

bind ctb_timebase ctb_timebase_chk #(.N_TMR(N_TMR)) u_chk (
   .clk     (clk),
   .por_n   (por_n),
   .ext_rst (ext_rst),
   .stop_wr (stop_wr),
   .flag_clr(flag_clr),
   .core_rst(core_rst),
   .clk_en  (clk_en),
   .mc_stb  (mc_stb),
   .tmr_tick(tmr_tick),
   .por_flag(por_flag)
);

// File: tb/ctb_timebase_test.sv
module ctb_timebase_test;

   localparam int CLK_P  = 10;
   localparam int SETTLE = 16;

   typedef struct {
      int         cyc;
      logic [6:0] val;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_rst = 1'b0;
   logic       stop_wr = 1'b0;
   logic [3:0] wake_evt = '0;
   logic [2:0] rate_sel = 3'b010;
   logic       flag_clr = 1'b0;
   logic       core_rst, clk_en, mc_stb, por_flag;
   logic [2:0] tmr_tick;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t q[$];

   ctb_timebase #(.SETTLE_CLKS(SETTLE)) uut (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .stop_wr(stop_wr),
      .wake_evt(wake_evt), .rate_sel(rate_sel), .flag_clr(flag_clr),
      .core_rst(core_rst), .clk_en(clk_en), .mc_stb(mc_stb),
      .tmr_tick(tmr_tick), .por_flag(por_flag)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // output vector: {core_rst, clk_en, mc_stb, tmr_tick[2:0], por_flag}
   task automatic expect_at(input int c, input logic [6:0] v, input string t);
      exp_t e;
      e.cyc = c; e.val = v; e.tag = t;
      q.push_back(e);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: pops expectations due this cycle
   always @(negedge clk) begin
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         logic [6:0] obs;
         e = q.pop_front();
         obs = {core_rst, clk_en, mc_stb, tmr_tick, por_flag};
         n_chk++;
         if (e.cyc != cyc || obs !== e.val) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %b expected %b", e.tag, cyc, obs, e.val);
         end
      end
   end

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      expect_at(1, 7'b1000001, "R2 reset state");
      wait_until(3);
      por_n = 1'b1;
      // R1 hold then release; R4 and R5 first strobes with timer 1 fast
      expect_at(18, 7'b1000001, "R1 still held");
      expect_at(19, 7'b0100001, "R1 released");
      expect_at(21, 7'b0100001, "R4 no strobe mid cycle");
      expect_at(22, 7'b0110101, "R4 R5 first mc strobe");
      expect_at(26, 7'b0110101, "R5 second strobe");
      expect_at(30, 7'b0111111, "R5 slow ticks on third");
      expect_at(31, 7'b0100001, "R4 strobe one cycle");
      wait_until(33);
      flag_clr = 1'b1;
      expect_at(34, 7'b0110100, "R2 flag cleared");
      wait_until(34);
      flag_clr = 1'b0;
      wait_until(35);
      ext_rst = 1'b1;
      expect_at(35, 7'b1100000, "R3 core reset same cycle");
      expect_at(37, 7'b1100000, "R3 strobes blocked");
      expect_at(38, 7'b0100000, "R3 flag unchanged");
      expect_at(41, 7'b0110100, "R3 prescaler restarted");
      expect_at(49, 7'b0111110, "R3 slow restart");
      wait_until(38);
      ext_rst = 1'b0;
      wait_until(50);
      wake_evt = 4'hF;
      rate_sel = 3'b101;
      expect_at(51, 7'b0100000, "R8 wake ignored running");
      expect_at(53, 7'b0111010, "R8 R5 pattern kept new rates");
      expect_at(57, 7'b0111010, "R5 rates 101");
      expect_at(61, 7'b0111110, "R5 slow tick");
      wait_until(51);
      wake_evt = '0;
      wait_until(62);
      stop_wr = 1'b1;
      expect_at(63, 7'b0000000, "R6 stop entered");
      expect_at(72, 7'b0000000, "R6 stop held");
      wait_until(63);
      stop_wr = 1'b0;
      wait_until(74);
      wake_evt = 4'b0100;
      expect_at(90, 7'b0000000, "R7 settling");
      expect_at(91, 7'b0100000, "R7 resumed");
      expect_at(94, 7'b0111010, "R7 prescaler from zero");
      expect_at(102, 7'b0111110, "R7 slow from zero");
      wait_until(75);
      wake_evt = '0;
      wait_until(103);
      stop_wr = 1'b1;
      expect_at(104, 7'b0000000, "R6 second stop");
      wait_until(104);
      stop_wr = 1'b0;
      wait_until(107);
      ext_rst = 1'b1;
      expect_at(107, 7'b1000000, "R9 reset in stop");
      expect_at(123, 7'b0000000, "R9 settling");
      expect_at(124, 7'b0100000, "R9 resumed");
      wait_until(108);
      ext_rst = 1'b0;
      wait_until(126);
      por_n = 1'b0;
      expect_at(126, 7'b1000001, "R2 flag set by power-up");
      wait_until(128);
      por_n = 1'b1;
      expect_at(143, 7'b1000001, "R1 second hold");
      expect_at(144, 7'b0100001, "R1 second release");
      wait_until(146);
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule